// File: doc/BRIEF.md
# Rotating-Start Bus Arbiter with Log-Depth Availability Scan

This block decides which of N requesters may own a shared bus. A requester raises its request line and waits for its grant bit and the acknowledge. It keeps the bus for as long as its request stays high. Dropping the request hands the bus back.

While the bus is free, the block uses a priority chain. A position wins if it is requesting and the bus is still available when the chain reaches it. Availability passes to the next position only if the current position is not requesting. The chain starts at a movable pointer and wraps from the last position to the first. After every grant, the pointer moves to the position just after the winner, so priority rotates between arbitrations.

The chain is not built as a ripple. The request vector is rotated so that the start position becomes index 0. An AND-scan is then taken over the inverted requests in log2(N) levels, and the result is rotated back into place.

Top module: `cyc_prefix_arbiter`

## Requirements
- R1: After reset is asserted (rst_ni low), grant_o and ack_o are 0 and the start pointer is position 0.
- R2: grant_o is always zero or one-hot. While the bus is free and req_i is all zero at a clock edge, grant_o stays zero after that edge.
- R3: With the bus free, the edge that samples req_i grants the first requesting position found when scanning upward from the start pointer, wrapping from N-1 to 0. Bit i of grant_o and of req_i belongs to requester i.
- R4: A grant appears on the clock edge that samples the request. ack_o is high exactly when grant_o is non-zero.
- R5: While the owner's request bit stays high, grant_o holds its value. Changes on the other request bits have no effect on grant_o.
- R6: On the first edge at which the owner's request bit is low, grant_o and ack_o clear. The following edge is the earliest at which a new grant can be issued, so at least one cycle passes with no owner.
- R7: After a grant to position k, the start pointer becomes (k+1) mod N.
- R8: With N=8, the grant matches a linear-ripple model of the chain for every one of the 256 request patterns at each of the 8 start positions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | N | Request lines, one per requester; dropping the owner's bit releases the bus |
| grant_o | output | N | One-hot grant, registered |
| ack_o | output | 1 | High while a requester owns the bus |

## Verification
Every result is registered, so it is due on the first rising edge after the request pattern is driven. Request changes are driven on the falling edge. A cycle model in the bench advances on the rising edge, and grant_o and ack_o are compared with it on the next falling edge. A release clears the grant one edge after the owner's bit drops. The model therefore expects an empty grant for that cycle before any new winner appears. To reach each start position before a pattern is applied, the bench first grants a single requester and then releases it, so the pointer is placed only through the ports.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic {ROT_DOWN = 1'b0, ROT_UP = 1'b1} rot_dir_e;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/arb_rotate.sv
// log2(N)-stage barrel rotator; DIR picks direction
module arb_rotate
  import arb_pkg::*;
#(
  parameter int       N   = 8,
  parameter rot_dir_e DIR = ROT_DOWN,
  localparam int      IW  = idx_w(N)
) (
  input  logic [N-1:0]  d_i,
  input  logic [IW-1:0] amt_i,
  output logic [N-1:0]  q_o
);
  logic [N-1:0] v, t;

  generate
    if (DIR == ROT_DOWN) begin : g_down
      // q[i] = d[(i + amt) mod N]
      always_comb begin
        v = d_i;
        t = d_i;
        for (int s = 0; s < IW; s++) begin
          if (amt_i[s]) begin
            for (int i = 0; i < N; i++) t[i] = v[(i + (1 << s)) % N];
            v = t;
          end
        end
        q_o = v;
      end
    end else begin : g_up
      // q[i] = d[(i - amt) mod N]
      always_comb begin
        v = d_i;
        t = d_i;
        for (int s = 0; s < IW; s++) begin
          if (amt_i[s]) begin
            for (int i = 0; i < N; i++) t[i] = v[(i + N - ((1 << s) % N)) % N];
            v = t;
          end
        end
        q_o = v;
      end
    end
  endgenerate
endmodule

// File: rtl/arb_prefix_and.sv
// Exclusive AND-scan, Kogge-Stone, ceil(log2 N) levels
module arb_prefix_and #(
  parameter int N = 8
) (
  input  logic [N-1:0] free_i,
  output logic [N-1:0] avail_o
);
  logic [N-1:0] lvl, nxt;

  always_comb begin
    lvl = free_i;
    nxt = free_i;
    for (int k = 0; (1 << k) < N; k++) begin
      nxt = lvl;
      for (int i = 0; i < N; i++) begin
        if (i >= (1 << k)) nxt[i] = lvl[i] & lvl[i - (1 << k)];
      end
      lvl = nxt;
    end
    avail_o = {lvl[N-2:0], 1'b1};
  end
endmodule

// File: rtl/arb_pick.sv
// Cyclic priority pick: rotate start to 0, scan, rotate back
module arb_pick
  import arb_pkg::*;
#(
  parameter int  N  = 8,
  localparam int IW = idx_w(N)
) (
  input  logic [N-1:0]  want_i,
  input  logic [IW-1:0] start_i,
  output logic [N-1:0]  pick_o,
  output logic [IW-1:0] pick_idx_o
);
  logic [N-1:0] want_rot, avail_rot, pick_rot;

  arb_rotate #(.N(N), .DIR(ROT_DOWN)) u_rot_in (
    .d_i(want_i), .amt_i(start_i), .q_o(want_rot)
  );

  arb_prefix_and #(.N(N)) u_scan (
    .free_i(~want_rot), .avail_o(avail_rot)
  );

  assign pick_rot = want_rot & avail_rot;

  arb_rotate #(.N(N), .DIR(ROT_UP)) u_rot_out (
    .d_i(pick_rot), .amt_i(start_i), .q_o(pick_o)
  );

  always_comb begin
    pick_idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (pick_o[i]) pick_idx_o = pick_idx_o | IW'(i);
    end
  end
endmodule

// File: rtl/cyc_prefix_arbiter.sv
module cyc_prefix_arbiter
  import arb_pkg::*;
#(
  parameter int  N  = 8,
  localparam int IW = idx_w(N)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o,
  output logic         ack_o
);
  logic [N-1:0]  grant_q, pick;
  logic [IW-1:0] start_q, pick_idx, start_nxt;
  logic          ack_q, owned, owner_keeps;

  arb_pick #(.N(N)) u_pick (
    .want_i(req_i), .start_i(start_q), .pick_o(pick), .pick_idx_o(pick_idx)
  );

  assign owned       = |grant_q;
  assign owner_keeps = |(grant_q & req_i);
  assign start_nxt   = (pick_idx == IW'(N - 1)) ? '0 : pick_idx + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_q <= '0;
      start_q <= '0;
      ack_q   <= 1'b0;
    end else if (owned) begin
      if (!owner_keeps) begin
        grant_q <= '0;
        ack_q   <= 1'b0;
      end
    end else if (|pick) begin
      grant_q <= pick;
      ack_q   <= 1'b1;
      start_q <= start_nxt;
    end
  end

  assign grant_o = grant_q;
  assign ack_o   = ack_q;
endmodule

// File: rtl/arb_chk.sv
module arb_chk #(
  parameter int N = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [N-1:0] req_i,
  input logic [N-1:0] grant_o,
  input logic         ack_o
);
  AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o)); // R2

  AST_IDLE_STAYS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o == '0 && req_i == '0) |=> (grant_o == '0)); // R2

  AST_ACK_TRACKS_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o == (grant_o != '0)); // R4

  AST_GRANT_WAS_REQUESTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o == '0) |=> ((grant_o == '0) || ((grant_o & $past(req_i)) != '0))); // R3

  AST_OWNER_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((grant_o & req_i) != '0) |=> (grant_o == $past(grant_o))); // R5

  AST_RELEASE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o != '0 && (grant_o & req_i) == '0) |=> (grant_o == '0 && !ack_o)); // R6
endmodule

bind cyc_prefix_arbiter arb_chk #(.N(N)) u_arb_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .grant_o(grant_o), .ack_o(ack_o)
);

// File: tb/cyc_prefix_arbiter_bench.sv
`timescale 1ns/1ps
module cyc_prefix_arbiter_bench;
  localparam int N = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] req_i = '0;
  logic [N-1:0] grant_o;
  logic         ack_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // model state
  bit           m_own = 1'b0;
  int           m_idx = 0;
  int           m_ptr = 0;
  logic [N-1:0] exp_g = '0;

  always #10 clk_i = ~clk_i;

  cyc_prefix_arbiter #(.N(N)) u_cyc_prefix_arbiter (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .grant_o(grant_o), .ack_o(ack_o)
  );

  // linear ripple chain starting at ptr
  function automatic logic [N-1:0] ripple(input logic [N-1:0] w, input int ptr);
    logic [N-1:0] g = '0;
    bit avail = 1'b1;
    for (int j = 0; j < N; j++) begin
      int p = (ptr + j) % N;
      g[p]  = w[p] & avail;
      avail = avail & ~w[p];
    end
    return g;
  endfunction

  task automatic check(input string tag);
    checks++;
    if (grant_o !== exp_g || ack_o !== (exp_g != '0)) begin
      fails++;
      $display("FAIL %s: grant=%b ack=%b expected grant=%b ack=%b",
               tag, grant_o, ack_o, exp_g, (exp_g != '0));
    end
  endtask

  // at negedge: drive, step one edge, update model, check at next negedge
  task automatic tick(input logic [N-1:0] r, input string tag);
    logic [N-1:0] g;
    req_i = r;
    @(posedge clk_i);
    if (m_own) begin
      if (!r[m_idx]) m_own = 1'b0;
    end else begin
      g = ripple(r, m_ptr);
      for (int i = 0; i < N; i++) begin
        if (g[i]) begin
          m_own = 1'b1;
          m_idx = i;
          m_ptr = (i + 1) % N;
        end
      end
    end
    exp_g = m_own ? (N'(1) << m_idx) : '0;
    @(negedge clk_i);
    check(tag);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7781));
    repeat (3) @(negedge clk_i);
    exp_g = '0;
    check("R1");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1");

    // R1/R3: pointer at 0 after reset
    tick(8'b1000_0001, "R1");
    // R5: others toggle, owner keeps
    tick(8'b1111_1111, "R5");
    tick(8'b0100_0001, "R5");
    // R6: release then idle cycle
    tick(8'b1111_1110, "R6");
    // R7: pointer at 1 -> bit1 wins
    tick(8'b1111_1110, "R7");
    tick(8'b0000_0000, "R6");
    // R2: nothing requested
    tick(8'b0000_0000, "R2");
    tick(8'b0000_0000, "R2");
    // R3: wrap from top position
    tick(8'b0000_0100, "R3");
    tick(8'b0000_0000, "R6");
    tick(8'b1000_0011, "R3");
    tick(8'b0000_0000, "R6");
    tick(8'b1000_0011, "R3");
    tick(8'b0000_0000, "R6");

    // R8: every pattern at every start
    for (int s = 0; s < N; s++) begin
      for (int p = 0; p < (1 << N); p++) begin
        tick(N'(1) << ((s + N - 1) % N), "R7");
        tick('0, "R6");
        tick(N'(p), "R8");
        tick('0, "R6");
      end
    end

    // random traffic, owner usually keeps its bit
    for (int k = 0; k < 3000; k++) begin
      logic [N-1:0] r = N'($urandom);
      if (m_own && ($urandom % 4 != 0)) r[m_idx] = 1'b1;
      if ($urandom % 8 == 0) r = '0;
      tick(r, "R3");
    end

    // R1: reset mid-ownership
    tick(8'b0010_0000, "R4");
    rst_ni = 1'b0;
    #1;
    m_own = 1'b0; m_ptr = 0; exp_g = '0;
    check("R1");
    @(negedge clk_i);
    rst_ni = 1'b1;
    tick(8'b1000_0001, "R1");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule